// File: doc/BRIEF.md
# I2C Master Address-Phase and Command Sequencer

This block sequences the address phase and the data-byte count of an I2C master. It does not produce SCL/SDA bit timing. It drives a byte-level bus engine, issuing one operation at a time: START, repeated START, STOP, byte write or byte read. It then waits for the engine's completion strobe and the slave's acknowledge bit. From a command word it builds either a one-byte address for 7-bit targets or a two-byte address for 10-bit targets. It then moves the requested number of data bytes.

A second command can sit in a one-entry queue. When the current command ends without STOP, the block issues a repeated START and runs the queued command. A 10-bit read uses this path. The first command is a zero-length 10-bit write with no STOP. The queued command is a 10-bit read with the repeat-same flag set, so only the header byte is sent after the repeated START. If the slave NACKs an address byte or a written data byte, the transfer ends with STOP, a sticky flag is raised and the queue is emptied.

Top module: `i2c10_seq`

## Requirements
- R1: With `cmd_ten`=0 the address phase is a single write of `{cmd_addr[6:0], cmd_read}`; `cmd_addr[9:7]` has no effect.
- R2: With `cmd_ten`=1 and `cmd_rsame`=0 the address phase is two writes: first `{5'b11110, cmd_addr[9:8], cmd_read}`, then `cmd_addr[7:0]`.
- R3: With `cmd_ten`=1 and `cmd_rsame`=1 only the header byte `{5'b11110, cmd_addr[9:8], cmd_read}` is written after the (repeated) START; no second address byte follows.
- R4: After the address phase a write command issues `cmd_count` byte writes carrying `wr_data`, with one `wr_pop` pulse per acknowledged data byte; a count of 0 ends the command right after the address phase.
- R5: A read command issues `cmd_count` byte reads; `eng_last` is 1 on the final read only (master NACK) and 0 on all others; each read completion gives a `rd_valid` pulse with the byte on `rd_data`.
- R6: A command with `cmd_stop`=1 ends with a STOP; when the STOP completes, `done` pulses for exactly one clock and `busy` falls.
- R7: A command with `cmd_stop`=0 whose queued command exists (`nxt_load` seen) is followed directly by a repeated START and the queued command; with no queued command the block holds the bus with `eng_req`=0 and `busy`=1 until `nxt_load`.
- R8: A NACK (`eng_ack`=0) on any address byte or written data byte makes the next operation a STOP, sets `nack_flag` until the next `cmd_load`, and discards the queued command.
- R9: After reset `busy`, `done`, `nack_flag`, `rd_valid` and `eng_req` are 0; `busy` is 1 from command acceptance until the final STOP completes, and `eng_req` is never 1 while idle.
- R10: `eng_req` stays 1 with a stable `eng_op` until `eng_done`; operation codes are START=1, repeated START=2, STOP=3, WRITE=4, READ=5, and `eng_tx` is 0 for all but writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load | input | 1 | Accept the command fields as the current command (taken only while idle) |
| nxt_load | input | 1 | Store the command fields in the one-entry queue |
| cmd_addr | input | 10 | Target address |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_stop | input | 1 | End the command with STOP |
| cmd_ten | input | 1 | 10-bit addressing |
| cmd_rsame | input | 1 | Send only the 10-bit header byte |
| cmd_count | input | CNT_W | Number of data bytes |
| wr_data | input | 8 | Next byte to write |
| wr_pop | output | 1 | Write byte consumed |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | rd_data valid pulse |
| eng_req | output | 1 | Operation request to the byte engine |
| eng_op | output | 3 | Operation code |
| eng_tx | output | 8 | Byte to transmit |
| eng_last | output | 1 | Final read: master answers NACK |
| eng_done | input | 1 | Engine finished the operation |
| eng_ack | input | 1 | Slave acknowledged the written byte |
| eng_rx | input | 8 | Byte received by the engine |
| busy | output | 1 | Command in progress or bus held |
| done | output | 1 | Command ending in STOP finished |
| nack_flag | output | 1 | Sticky NACK abort status |

## Verification
The sequencer is driven with a 7-bit write whose upper address bits are non-zero, a 7-bit multi-byte read, a 10-bit write and the two-command 10-bit read. Together these separate the one-byte, two-byte and header-only address forms, and show whether the read/write bit lands in bit 0. A command ending without STOP is run both with an empty queue and with a queued command, which tells a hold apart from a repeated START. NACKs are placed on an address byte, with a command queued, and on a data byte. These show the abort STOP, that the flag persists and is then cleared, and that the queued command is discarded.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

    localparam int TA_W = 10;
    localparam logic [4:0] TEN_HDR = 5'b11110;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_START  = 3'd1,
        OP_RSTART = 3'd2,
        OP_STOP   = 3'd3,
        OP_WRITE  = 3'd4,
        OP_READ   = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_ADR1, ST_ADR2, ST_DATA, ST_STOP, ST_HOLD
    } st_e;

    typedef struct packed {
        logic [TA_W-1:0] addr;
        logic            read;
        logic            stop;
        logic            ten;
        logic            rsame;
    } cmd_t;

    function automatic logic [7:0] hdr_byte(cmd_t c);
        return c.ten ? {TEN_HDR, c.addr[9:8], c.read} : {c.addr[6:0], c.read};
    endfunction

endpackage

// File: rtl/i2c10_addr_form.sv
module i2c10_addr_form
    import i2c10_pkg::*;
(
    input  cmd_t       cur,
    output logic [7:0] first_b,
    output logic [7:0] second_b,
    output logic       two_b
);
    always_comb begin
        first_b  = hdr_byte(cur);
        second_b = cur.addr[7:0];
        two_b    = cur.ten && !cur.rsame;
    end
endmodule

// File: rtl/i2c10_cmd_slot.sv
module i2c10_cmd_slot
    import i2c10_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  cmd_t             din,
    input  logic [CNT_W-1:0] din_cnt,
    input  logic             take,
    input  logic             flush,
    output logic             valid,
    output cmd_t             dout,
    output logic [CNT_W-1:0] dout_cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            dout     <= '0;
            dout_cnt <= '0;
        end else if (flush) begin
            valid <= 1'b0;
        end else if (wr) begin
            valid    <= 1'b1;
            dout     <= din;
            dout_cnt <= din_cnt;
        end else if (take) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c10_byte_cnt.sv
module i2c10_byte_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero,
    output logic             one
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec && cnt_q != '0) cnt_q <= cnt_q - ONE;
    end

    assign zero = (cnt_q == '0);
    assign one  = (cnt_q == ONE);
endmodule

// File: rtl/i2c10_seq.sv
module i2c10_seq
    import i2c10_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_load,
    input  logic             nxt_load,
    input  logic [9:0]       cmd_addr,
    input  logic             cmd_read,
    input  logic             cmd_stop,
    input  logic             cmd_ten,
    input  logic             cmd_rsame,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic [7:0]       wr_data,
    output logic             wr_pop,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             eng_req,
    output logic [2:0]       eng_op,
    output logic [7:0]       eng_tx,
    output logic             eng_last,
    input  logic             eng_done,
    input  logic             eng_ack,
    input  logic [7:0]       eng_rx,
    output logic             busy,
    output logic             done,
    output logic             nack_flag
);
    st_e  st_q, st_d;
    cmd_t cur_q, cmd_in, slot_cmd;
    logic [CNT_W-1:0] slot_cnt;
    logic slot_valid, held_q;
    logic ld_cur, ld_slot, cnt_dec, abort, fin, set_held, stop_fin;
    logic cnt_zero, cnt_one, two_b;
    logic [7:0] first_b, second_b;
    op_e  op;

    assign cmd_in = '{addr: cmd_addr, read: cmd_read, stop: cmd_stop,
                      ten: cmd_ten, rsame: cmd_rsame};

    i2c10_addr_form u_form (
        .cur(cur_q), .first_b(first_b), .second_b(second_b), .two_b(two_b)
    );

    i2c10_cmd_slot #(.CNT_W(CNT_W)) u_slot (
        .clk(clk), .rst(rst), .wr(nxt_load), .din(cmd_in), .din_cnt(cmd_count),
        .take(ld_slot), .flush(abort), .valid(slot_valid),
        .dout(slot_cmd), .dout_cnt(slot_cnt)
    );

    i2c10_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(ld_cur || ld_slot),
        .load_val(ld_slot ? slot_cnt : cmd_count),
        .dec(cnt_dec), .zero(cnt_zero), .one(cnt_one)
    );

    always_comb begin
        st_d = st_q; ld_cur = 1'b0; ld_slot = 1'b0; cnt_dec = 1'b0;
        abort = 1'b0; fin = 1'b0; set_held = 1'b0; stop_fin = 1'b0;
        case (st_q)
            ST_IDLE:  if (cmd_load) begin ld_cur = 1'b1; st_d = ST_START; end
            ST_START: if (eng_done) begin set_held = 1'b1; st_d = ST_ADR1; end
            ST_ADR1: if (eng_done) begin
                if (!eng_ack)      abort = 1'b1;
                else if (two_b)    st_d = ST_ADR2;
                else if (cnt_zero) fin = 1'b1;
                else               st_d = ST_DATA;
            end
            ST_ADR2: if (eng_done) begin
                if (!eng_ack)      abort = 1'b1;
                else if (cnt_zero) fin = 1'b1;
                else               st_d = ST_DATA;
            end
            ST_DATA: if (eng_done) begin
                if (!cur_q.read && !eng_ack) abort = 1'b1;
                else begin
                    cnt_dec = 1'b1;
                    if (cnt_one) fin = 1'b1;
                end
            end
            ST_HOLD: if (slot_valid) begin ld_slot = 1'b1; st_d = ST_START; end
            ST_STOP: if (eng_done) begin stop_fin = 1'b1; st_d = ST_IDLE; end
            default: st_d = ST_IDLE;
        endcase
        if (abort) st_d = ST_STOP;
        if (fin) begin
            if (cur_q.stop)      st_d = ST_STOP;
            else if (slot_valid) begin ld_slot = 1'b1; st_d = ST_START; end
            else                 st_d = ST_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            cur_q     <= '0;
            held_q    <= 1'b0;
            nack_flag <= 1'b0;
            done      <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            st_q     <= st_d;
            done     <= stop_fin;
            rd_valid <= eng_done && st_q == ST_DATA && cur_q.read;
            if (eng_done && st_q == ST_DATA && cur_q.read) rd_data <= eng_rx;
            if (ld_cur)       cur_q <= cmd_in;
            else if (ld_slot) cur_q <= slot_cmd;
            if (set_held)      held_q <= 1'b1;
            else if (stop_fin) held_q <= 1'b0;
            if (abort)       nack_flag <= 1'b1;
            else if (ld_cur) nack_flag <= 1'b0;
        end
    end

    always_comb begin
        op     = OP_NONE;
        eng_tx = 8'h00;
        case (st_q)
            ST_START: op = held_q ? OP_RSTART : OP_START;
            ST_ADR1:  begin op = OP_WRITE; eng_tx = first_b;  end
            ST_ADR2:  begin op = OP_WRITE; eng_tx = second_b; end
            ST_DATA:  if (cur_q.read) op = OP_READ;
                      else begin op = OP_WRITE; eng_tx = wr_data; end
            ST_STOP:  op = OP_STOP;
            default:  op = OP_NONE;
        endcase
    end

    assign eng_op   = op;
    assign eng_req  = (op != OP_NONE);
    assign eng_last = (st_q == ST_DATA) && cur_q.read && cnt_one;
    assign wr_pop   = eng_done && st_q == ST_DATA && !cur_q.read && eng_ack;
    assign busy     = (st_q != ST_IDLE);

endmodule

// File: rtl/i2c10_seq_chk.sv
module i2c10_seq_chk
    import i2c10_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       eng_req,
    input logic [2:0] eng_op,
    input logic       eng_last,
    input logic       eng_done,
    input logic       nack_flag
);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !eng_req);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_op)));

    // R8
    abort_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nack_flag) |-> (eng_req && eng_op == 3'(OP_STOP)));

    // R5
    last_read_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_req && eng_last) |-> eng_op == 3'(OP_READ));
endmodule

bind i2c10_seq i2c10_seq_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .eng_req(eng_req),
    .eng_op(eng_op), .eng_last(eng_last), .eng_done(eng_done),
    .nack_flag(nack_flag)
);

// File: tb/i2c10_seq_bench.sv
module i2c10_seq_bench;
    localparam int CNT_W = 8;
    localparam logic [2:0] S = 3'd1, RS = 3'd2, P = 3'd3, W = 3'd4, RD = 3'd5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_load = 1'b0, nxt_load = 1'b0;
    logic [9:0] cmd_addr = '0;
    logic cmd_read = 1'b0, cmd_stop = 1'b0, cmd_ten = 1'b0, cmd_rsame = 1'b0;
    logic [CNT_W-1:0] cmd_count = '0;
    logic [7:0] wr_data = 8'hC0;
    logic wr_pop, rd_valid, eng_req, eng_last, busy, done, nack_flag;
    logic [7:0] rd_data, eng_tx;
    logic [2:0] eng_op;
    logic eng_done = 1'b0, eng_ack = 1'b1;
    logic [7:0] eng_rx = 8'h90;

    int checks = 0, errors = 0;
    int txn_idx = 0, nack_at = -1, eng_cnt = 0;
    int done_cnt = 0, rd_cnt = 0;
    logic [11:0] expq[$];

    always #5 clk = ~clk;

    i2c10_seq #(.CNT_W(CNT_W)) u_i2c10_seq (
        .clk(clk), .rst(rst), .cmd_load(cmd_load), .nxt_load(nxt_load),
        .cmd_addr(cmd_addr), .cmd_read(cmd_read), .cmd_stop(cmd_stop),
        .cmd_ten(cmd_ten), .cmd_rsame(cmd_rsame), .cmd_count(cmd_count),
        .wr_data(wr_data), .wr_pop(wr_pop), .rd_data(rd_data),
        .rd_valid(rd_valid), .eng_req(eng_req), .eng_op(eng_op),
        .eng_tx(eng_tx), .eng_last(eng_last), .eng_done(eng_done),
        .eng_ack(eng_ack), .eng_rx(eng_rx), .busy(busy), .done(done),
        .nack_flag(nack_flag)
    );

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic expect_op(logic [2:0] op, logic [7:0] b, logic last);
        expq.push_back({op, b, last});
    endtask

    // byte engine model and scoreboard monitor
    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (wr_pop) wr_data <= wr_data + 8'd1;
        if (rd_valid) rd_cnt <= rd_cnt + 1;
        if (done) done_cnt <= done_cnt + 1;
        if (eng_cnt > 0) begin
            eng_cnt <= eng_cnt - 1;
            if (eng_cnt == 1) eng_done <= 1'b1;
        end else if (!rst && eng_req && !eng_done) begin
            logic [11:0] got;
            got = {eng_op, eng_tx, (eng_op == RD) ? eng_last : 1'b0};
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected op got %0h expected none", got);
            end else begin
                logic [11:0] e;
                e = expq.pop_front();
                if (got != e) begin
                    errors++;
                    $display("FAIL R1-form/R10 op item got %0h expected %0h", got, e);
                end
            end
            eng_ack <= (txn_idx != nack_at);
            eng_rx  <= 8'h90 + 8'(txn_idx);
            txn_idx <= txn_idx + 1;
            eng_cnt <= 2;
        end
    end

    task automatic issue(bit nxt, logic [9:0] a, bit rd, bit sp, bit ten, bit rs, int n);
        @(negedge clk);
        cmd_addr = a; cmd_read = rd; cmd_stop = sp; cmd_ten = ten;
        cmd_rsame = rs; cmd_count = CNT_W'(n);
        if (nxt) nxt_load = 1'b1; else cmd_load = 1'b1;
        @(negedge clk);
        cmd_load = 1'b0; nxt_load = 1'b0;
    endtask

    task automatic wait_idle(string req);
        int t;
        t = 0;
        @(negedge clk);
        while (busy && t < 1000) begin @(negedge clk); t++; end
        if (t >= 1000) check({req, " watchdog"}, 1, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] wb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 busy", busy, 0);
        check("R9 done", done, 0);
        check("R9 nack_flag", nack_flag, 0);
        check("R9 rd_valid", rd_valid, 0);
        check("R9 eng_req", eng_req, 0);

        // R1 R4 7-bit write, upper address bits set
        done_cnt = 0; wb = wr_data;
        expect_op(S, 0, 0); expect_op(W, 8'hB4, 0);
        expect_op(W, wb, 0); expect_op(W, wb + 8'd1, 0); expect_op(P, 0, 0);
        issue(0, 10'h35A, 0, 1, 0, 0, 2);
        @(negedge clk);
        check("R9 busy after accept", busy, 1);
        wait_idle("R1");
        check("R1 queue drained", expq.size(), 0);
        check("R4 pops", 32'(wr_data - wb), 2);
        check("R6 done count", done_cnt, 1);

        // R5 7-bit read of three bytes
        done_cnt = 0; rd_cnt = 0;
        expect_op(S, 0, 0); expect_op(W, 8'h43, 0);
        expect_op(RD, 0, 0); expect_op(RD, 0, 0); expect_op(RD, 0, 1);
        expect_op(P, 0, 0);
        issue(0, 10'h021, 1, 1, 0, 0, 3);
        wait_idle("R5");
        check("R5 queue drained", expq.size(), 0);
        check("R5 rd_valid count", rd_cnt, 3);
        check("R5 last rd_data", rd_data, 8'h90 + 8'(txn_idx - 2));

        // R2 ten-bit write of one byte
        done_cnt = 0; wb = wr_data;
        expect_op(S, 0, 0); expect_op(W, 8'hF4, 0); expect_op(W, 8'hA5, 0);
        expect_op(W, wb, 0); expect_op(P, 0, 0);
        issue(0, 10'h2A5, 0, 1, 1, 0, 1);
        wait_idle("R2");
        check("R2 queue drained", expq.size(), 0);
        check("R6 done count ten write", done_cnt, 1);

        // R3 R7 ten-bit read as two commands
        done_cnt = 0; rd_cnt = 0;
        expect_op(S, 0, 0); expect_op(W, 8'hF4, 0); expect_op(W, 8'hA5, 0);
        expect_op(RS, 0, 0); expect_op(W, 8'hF5, 0);
        expect_op(RD, 0, 0); expect_op(RD, 0, 1); expect_op(P, 0, 0);
        issue(0, 10'h2A5, 0, 0, 1, 0, 0);
        issue(1, 10'h2A5, 1, 1, 1, 1, 2);
        wait_idle("R3");
        check("R3 queue drained", expq.size(), 0);
        check("R3 rd count", rd_cnt, 2);
        check("R7 single done", done_cnt, 1);

        // R7 hold without queued command
        done_cnt = 0; wb = wr_data;
        expect_op(S, 0, 0); expect_op(W, 8'h20, 0); expect_op(W, wb, 0);
        issue(0, 10'h010, 0, 0, 0, 0, 1);
        wait_cycles(30);
        check("R7 hold busy", busy, 1);
        check("R7 hold eng_req", eng_req, 0);
        check("R7 hold no done", done_cnt, 0);
        check("R7 hold ops", expq.size(), 0);
        expect_op(RS, 0, 0); expect_op(W, 8'h22, 0); expect_op(P, 0, 0);
        issue(1, 10'h011, 0, 1, 0, 0, 0);
        wait_idle("R7");
        check("R7 resume queue drained", expq.size(), 0);
        check("R7 done after resume", done_cnt, 1);

        // R8 NACK on address byte with a queued command
        done_cnt = 0;
        nack_at = txn_idx + 1;
        expect_op(S, 0, 0); expect_op(W, 8'h66, 0); expect_op(P, 0, 0);
        issue(0, 10'h033, 0, 0, 0, 0, 2);
        issue(1, 10'h044, 0, 1, 0, 0, 1);
        wait_idle("R8");
        check("R8 nack_flag set", nack_flag, 1);
        check("R8 abort done", done_cnt, 1);
        check("R8 abort ops", expq.size(), 0);
        wait_cycles(5);
        check("R8 nack_flag sticky", nack_flag, 1);
        // queued command must be gone: a no-stop command now holds
        nack_at = -1;
        expect_op(S, 0, 0); expect_op(W, 8'h02, 0);
        issue(0, 10'h001, 0, 0, 0, 0, 0);
        wait_cycles(30);
        check("R8 queue discarded (hold)", busy, 1);
        check("R8 discarded ops", expq.size(), 0);
        check("R8 flag cleared by new command", nack_flag, 0);
        expect_op(RS, 0, 0); expect_op(W, 8'h02, 0); expect_op(P, 0, 0);
        issue(1, 10'h001, 0, 1, 0, 0, 0);
        wait_idle("R8");
        check("R8 resume drained", expq.size(), 0);

        // R8 NACK on a data byte
        done_cnt = 0; wb = wr_data;
        nack_at = txn_idx + 2;
        expect_op(S, 0, 0); expect_op(W, 8'h80, 0); expect_op(W, wb, 0);
        expect_op(P, 0, 0);
        issue(0, 10'h040, 0, 1, 0, 0, 3);
        wait_idle("R8");
        check("R8 data nack flag", nack_flag, 1);
        check("R8 data nack ops", expq.size(), 0);
        check("R4 no pop on nacked byte", 32'(wr_data - wb), 0);
        check("R6 done on abort", done_cnt, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule